// File: doc/BRIEF.md
# T1 Remote (Yellow) Alarm Detector

This block watches a received DS1 stream and raises a single remote-alarm flag, using one of two unrelated detection methods picked by a format select. With the superframe (D3/D4) format chosen, the detector looks at the second bit of every received channel byte once per frame. A frame in which nearly all channels carry a zero in that bit counts as alarm-bearing. The flag rises only after a long unbroken run of such frames and drops only after a shorter unbroken run of frames without the pattern. A frame counts as alarm-bearing when only a few channels fail the vote, so the detector still works when the line has some bit errors.

With the extended superframe (ESF) format chosen, the detector watches the facility data link bit by bit. It raises the flag as soon as it has seen eight zeros followed by eight ones. The flag stays up as long as every later data link bit repeats that 16-bit code. The first bit that breaks the repetition drops the flag, so a single line error removes the indication, and the system above this block has to integrate it. Both detectors run all the time, and the format select only picks which one drives the output.

Frames are counted in units of the frame strobe (one per 125 µs frame). With the default parameters, the set time is 600 ms (4800 frames) and the clear time is 200 ms (1600 frames).

Top module: `t1_yellow_alarm`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, yellow_alarm is 0.
- R2: Channel k occupies chan_bits[8k+7:8k], and its bit 2 is chan_bits[8k+6]. A strobed frame is alarm-bearing when at least MIN_ZERO_CH of the NUM_CH channels have that bit at 0.
- R3: In D3/D4 mode (fmt_esf=0), yellow_alarm rises in the cycle after the frame_stb of the SET_FRAMES-th alarm-bearing frame in a row, and not earlier.
- R4: While the alarm is low, a strobed frame that is not alarm-bearing restarts the set count from zero.
- R5: While the alarm is high, it falls in the cycle after the CLR_FRAMES-th non-bearing frame in a row, and an alarm-bearing frame restarts that clear count from zero.
- R6: In cycles without frame_stb, chan_bits has no effect on the D3/D4 detector.
- R7: In ESF mode (fmt_esf=1), yellow_alarm rises in the cycle after the accepted data link bit that completes eight 0s followed by eight 1s, in order of arrival.
- R8: Once set, the ESF flag stays high while each accepted bit equals the bit accepted 16 bits earlier. It falls in the cycle after the first accepted bit that does not.
- R9: A dl_bit presented with dl_valid low is ignored.
- R10: Both detectors run regardless of mode. fmt_esf=0 routes the D3/D4 result to yellow_alarm and fmt_esf=1 routes the ESF result, with no added cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fmt_esf | input | 1 | 0 selects D3/D4 detection, 1 selects ESF detection |
| frame_stb | input | 1 | One-cycle strobe marking a received frame on chan_bits |
| chan_bits | input | NUM_CH*8 | Received channel bytes, channel k at bits [8k+7:8k] |
| dl_bit | input | 1 | Facility data link bit |
| dl_valid | input | 1 | Qualifies dl_bit for one cycle |
| yellow_alarm | output | 1 | Remote alarm flag for the selected format |

## Verification
The bench builds the block with SET_FRAMES=12 and CLR_FRAMES=5, keeping NUM_CH=24 and MIN_ZERO_CH=20. With these values, full set and clear runs take only a few dozen frames. This makes it possible to sweep every count of zero channels from 0 to 24 through a complete set window, and to place interrupting frames at the last position before each threshold. The 16-bit data link code is walked bit by bit at its full length, with idle strobe gaps in between.

// File: rtl/yel_pkg.sv
package yel_pkg;

    localparam int unsigned DL_CODE_W = 16;
    // Oldest bit at the MSB: eight zeros then eight ones.
    localparam logic [DL_CODE_W-1:0] DL_CODE = 16'h00FF;
    localparam int unsigned BYTE_W    = 8;
    // Bit 2 of a channel byte (bit 1 being the MSB) sits at index 6.
    localparam int unsigned SIG_BIT_IX = 6;

    typedef enum logic {
        FMT_D4  = 1'b0,
        FMT_ESF = 1'b1
    } fmt_e;

endpackage

// File: rtl/yel_chan_vote.sv
module yel_chan_vote #(
    parameter int unsigned NUM_CH      = 24,
    parameter int unsigned MIN_ZERO_CH = 20
) (
    input  logic [NUM_CH*yel_pkg::BYTE_W-1:0] chan_bits,
    output logic                              frame_hit
);
    import yel_pkg::*;

    localparam int unsigned CW = $clog2(NUM_CH + 1);
    localparam logic [CW-1:0] THRESH = CW'(MIN_ZERO_CH);

    logic [NUM_CH-1:0] zero_v;
    logic [CW-1:0]     zero_cnt;

    genvar g;
    generate
        for (g = 0; g < NUM_CH; g++) begin : g_ch
            assign zero_v[g] = ~chan_bits[g*BYTE_W + SIG_BIT_IX];
        end
    endgenerate

    always_comb begin
        zero_cnt = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            zero_cnt = zero_cnt + CW'(zero_v[i]);
        end
        frame_hit = (zero_cnt >= THRESH);
    end

endmodule

// File: rtl/yel_persist_timer.sv
module yel_persist_timer #(
    parameter int unsigned SET_FRAMES = 4800,
    parameter int unsigned CLR_FRAMES = 1600
) (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_stb,
    input  logic frame_hit,
    output logic flag
);
    localparam int unsigned SW = $clog2(SET_FRAMES + 1);
    localparam int unsigned CW = $clog2(CLR_FRAMES + 1);
    localparam logic [SW-1:0] SET_LAST = SW'(SET_FRAMES - 1);
    localparam logic [CW-1:0] CLR_LAST = CW'(CLR_FRAMES - 1);

    typedef struct packed {
        logic          flag;
        logic [SW-1:0] set_cnt;
        logic [CW-1:0] clr_cnt;
    } tmr_t;

    tmr_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (frame_stb) begin
            if (!st_q.flag) begin
                st_d.clr_cnt = '0;
                if (frame_hit) begin
                    if (st_q.set_cnt == SET_LAST) begin
                        st_d.flag    = 1'b1;
                        st_d.set_cnt = '0;
                    end else begin
                        st_d.set_cnt = st_q.set_cnt + 1'b1;
                    end
                end else begin
                    st_d.set_cnt = '0;
                end
            end else begin
                st_d.set_cnt = '0;
                if (!frame_hit) begin
                    if (st_q.clr_cnt == CLR_LAST) begin
                        st_d.flag    = 1'b0;
                        st_d.clr_cnt = '0;
                    end else begin
                        st_d.clr_cnt = st_q.clr_cnt + 1'b1;
                    end
                end else begin
                    st_d.clr_cnt = '0;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag = st_q.flag;

endmodule

// File: rtl/yel_dl_matcher.sv
module yel_dl_matcher (
    input  logic clk,
    input  logic rst_n,
    input  logic dl_bit,
    input  logic dl_valid,
    output logic flag
);
    import yel_pkg::*;

    typedef struct packed {
        logic                 flag;
        logic [DL_CODE_W-1:0] sreg;
    } dl_t;

    dl_t st_q, st_d;
    logic [DL_CODE_W-1:0] shifted;

    always_comb begin
        st_d    = st_q;
        shifted = {st_q.sreg[DL_CODE_W-2:0], dl_bit};
        if (dl_valid) begin
            st_d.sreg = shifted;
            if (shifted == DL_CODE) begin
                st_d.flag = 1'b1;
            end else if (st_q.flag && (dl_bit != st_q.sreg[DL_CODE_W-1])) begin
                st_d.flag = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.flag <= 1'b0;
            // Preload ones so a code cannot complete before 16 real bits.
            st_q.sreg <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag = st_q.flag;

endmodule

// File: rtl/t1_yellow_alarm.sv
module t1_yellow_alarm #(
    parameter int unsigned NUM_CH      = 24,
    parameter int unsigned MIN_ZERO_CH = 20,
    parameter int unsigned SET_FRAMES  = 4800,
    parameter int unsigned CLR_FRAMES  = 1600
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  fmt_esf,
    input  logic                  frame_stb,
    input  logic [NUM_CH*8-1:0]   chan_bits,
    input  logic                  dl_bit,
    input  logic                  dl_valid,
    output logic                  yellow_alarm
);
    import yel_pkg::*;

    logic frame_hit;
    logic d4_flag;
    logic dl_flag;
    fmt_e fmt;

    assign fmt = fmt_e'(fmt_esf);

    yel_chan_vote #(
        .NUM_CH      (NUM_CH),
        .MIN_ZERO_CH (MIN_ZERO_CH)
    ) u_vote (
        .chan_bits (chan_bits),
        .frame_hit (frame_hit)
    );

    yel_persist_timer #(
        .SET_FRAMES (SET_FRAMES),
        .CLR_FRAMES (CLR_FRAMES)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame_stb (frame_stb),
        .frame_hit (frame_hit),
        .flag      (d4_flag)
    );

    yel_dl_matcher u_dl (
        .clk      (clk),
        .rst_n    (rst_n),
        .dl_bit   (dl_bit),
        .dl_valid (dl_valid),
        .flag     (dl_flag)
    );

    always_comb begin
        case (fmt)
            FMT_ESF: yellow_alarm = dl_flag;
            default: yellow_alarm = d4_flag;
        endcase
    end

endmodule

// File: rtl/yel_alarm_chk.sv
module yel_alarm_chk (
    input logic clk,
    input logic rst_n,
    input logic fmt_esf,
    input logic frame_stb,
    input logic frame_hit,
    input logic dl_bit,
    input logic dl_valid,
    input logic d4_flag,
    input logic dl_flag,
    input logic yellow_alarm
);
    assert_d4_rise_on_hit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(d4_flag) |-> ($past(frame_stb) && $past(frame_hit)));

    assert_d4_fall_on_miss_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(d4_flag) |-> ($past(frame_stb) && !$past(frame_hit)));

    assert_d4_idle_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(frame_stb) |-> $stable(d4_flag));

    assert_dl_rise_on_one_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dl_flag) |-> ($past(dl_valid) && $past(dl_bit)));

    assert_dl_idle_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(dl_valid) |-> $stable(dl_flag));

    assert_esf_out_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (fmt_esf && $past(fmt_esf) && !$past(dl_valid)) |-> $stable(yellow_alarm));

endmodule

bind t1_yellow_alarm yel_alarm_chk chk_i (.*);

// File: tb/t1_yellow_alarm_tb.sv
module t1_yellow_alarm_tb_top;

    localparam int NCH  = 24;
    localparam int MINZ = 20;
    localparam int SETF = 12;
    localparam int CLRF = 5;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            fmt_esf = 1'b0;
    logic            frame_stb = 1'b0;
    logic [NCH*8-1:0] chan_bits = '1;
    logic            dl_bit = 1'b0;
    logic            dl_valid = 1'b0;
    logic            yellow_alarm;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    t1_yellow_alarm #(
        .NUM_CH(NCH), .MIN_ZERO_CH(MINZ), .SET_FRAMES(SETF), .CLR_FRAMES(CLRF)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .fmt_esf(fmt_esf), .frame_stb(frame_stb),
        .chan_bits(chan_bits), .dl_bit(dl_bit), .dl_valid(dl_valid),
        .yellow_alarm(yellow_alarm)
    );

    task automatic check(input string req, input logic exp);
        checks++;
        if (yellow_alarm !== exp) begin
            errors++;
            $display("FAIL %s: yellow_alarm=%b expected=%b at %0t", req, yellow_alarm, exp, $time);
        end
    endtask

    // Channels 0..nz-1 carry bit 2 = 0; others 1. Other bits vary.
    function automatic logic [NCH*8-1:0] mk_frame(input int nz);
        logic [NCH*8-1:0] v;
        for (int k = 0; k < NCH; k++) begin
            v[k*8 +: 8] = 8'(k * 37 + 5);
            v[k*8 + 6]  = (k < nz) ? 1'b0 : 1'b1;
        end
        return v;
    endfunction

    task automatic frame(input int nz);
        @(negedge clk);
        chan_bits = mk_frame(nz);
        frame_stb = 1'b1;
        @(negedge clk);
        frame_stb = 1'b0;
        chan_bits = mk_frame(NCH - nz);
    endtask

    task automatic dl(input logic b);
        @(negedge clk);
        dl_bit = b;
        dl_valid = 1'b1;
        @(negedge clk);
        dl_valid = 1'b0;
        dl_bit = ~b;
    endtask

    task automatic dl_code(input string req);
        for (int i = 0; i < 16; i++) begin
            dl(i >= 8);
            check(req, 1'b1);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1", 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", 1'b0);

        // R4 with R2 boundary: 19 zeros breaks the run, 20 zeros counts
        for (int i = 0; i < SETF - 1; i++) frame(24);
        check("R3", 1'b0);
        frame(MINZ - 1);
        for (int i = 0; i < SETF - 1; i++) frame(MINZ);
        check("R4", 1'b0);
        frame(MINZ);
        check("R3", 1'b1);

        // R5 clear and restart
        for (int i = 0; i < CLRF - 1; i++) begin frame(0); check("R5", 1'b1); end
        frame(NCH);
        for (int i = 0; i < CLRF - 1; i++) frame(MINZ - 1);
        check("R5", 1'b1);
        frame(MINZ - 1);
        check("R5", 1'b0);

        // R2 sweep over every zero-channel count
        for (int n = 0; n <= NCH; n++) begin
            for (int i = 0; i < SETF; i++) frame(n);
            check("R2", (n >= MINZ) ? 1'b1 : 1'b0);
            for (int i = 0; i < CLRF; i++) frame(0);
            check("R2", 1'b0);
        end

        // R6 idle cycles with zero bits are not counted
        @(negedge clk);
        chan_bits = mk_frame(NCH);
        repeat (40) @(negedge clk);
        check("R6", 1'b0);
        for (int i = 0; i < SETF - 1; i++) frame(NCH);
        check("R6", 1'b0);
        frame(NCH);
        check("R6", 1'b1);
        for (int i = 0; i < CLRF; i++) frame(0);
        check("R5", 1'b0);

        // ESF mode
        @(negedge clk);
        fmt_esf = 1'b1;
        @(negedge clk);
        check("R10", 1'b0);
        dl(1); dl(0); dl(1); dl(1);
        for (int i = 0; i < 15; i++) begin
            dl(i >= 8);
            check("R7", 1'b0);
            @(negedge clk);
            dl_bit = ~dl_bit;
            repeat (2) @(negedge clk);
        end
        dl(1);
        check("R7", 1'b1);
        dl_code("R8");
        // R9: toggling dl_bit without valid keeps the flag
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            dl_bit = i[0];
        end
        check("R9", 1'b1);
        dl_code("R8");
        for (int i = 0; i < 7; i++) dl(1'b0);
        check("R8", 1'b1);
        dl(1'b1);
        check("R8", 1'b0);

        // R10: D3/D4 detector runs while ESF is selected
        for (int i = 0; i < SETF; i++) frame(NCH);
        check("R10", 1'b0);
        @(negedge clk);
        fmt_esf = 1'b0;
        #1;
        check("R10", 1'b1);
        for (int i = 0; i < 8; i++) dl(1'b0);
        for (int i = 0; i < 8; i++) dl(1'b1);
        for (int i = 0; i < CLRF; i++) frame(0);
        check("R10", 1'b0);
        @(negedge clk);
        fmt_esf = 1'b1;
        #1;
        check("R10", 1'b1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule